// File: doc/BRIEF.md
# LPC host bus cycle engine

This block is the host side of a Low Pin Count bus. An internal requester hands it one read or write at a time, giving an address, an address space (memory, IO or configuration), a size of 1, 2 or 4 bytes and write data. The block sorts each request into a standard memory cycle, an IO cycle, a firmware-hub cycle, a TPM cycle or a request that is not meant for the bus. It then drives the frame strobe and the 4-bit LAD bus nibble by nibble. It also turns the bus around, interprets the SYNC field and returns one response carrying read data and an abort flag.

Every bus cycle moves one byte, so wider requests become a run of byte cycles at rising addresses. When no device answers, or a device signals a fault, the engine aborts the cycle and reports all ones. A power-down input first raises the suspend status output and then parks the bus with the frame strobe low and LAD released.

Top module: `lpc_host_engine`

## Requirements
- R1: A 2-byte or 4-byte request (size code 1 or 2; code 3 acts as 4 bytes) runs as back-to-back single-byte cycles at base, base+1, and so on, followed by one response. Read byte i appears at rsp_rdata_o[8i+7:8i], and unused bytes read as zero.
- R2: A memory request below 1000000h that lies outside the firmware window runs as a standard cycle: START 0000 with the frame strobe low, then type nibble 0100 (read) or 0110 (write), then 8 address nibbles, most significant first.
- R3: A memory request in the firmware window 00F00000h to 00FFFFFFh uses START 1101 for a read and 1110 for a write. No type nibble is sent, and 8 address nibbles follow.
- R4: A memory request from FED00000h to FED40FFFh inclusive uses START 0101, then the memory type nibble and 8 address nibbles. FED41000h is not part of this window.
- R5: An IO request below 10000h uses START 0000 and type 0000 (read) or 0010 (write), then 4 address nibbles, most significant first. Write data follows low nibble first.
- R6: After the host fields come 1111 driven for one clock and then one released clock. After read data, or after the SYNC of a write, come two released clocks before the next START or the response.
- R7: A SYNC of 0000 means ready. 0101 and 0110 mean wait. 1001 means ready except in firmware-hub cycles. Every other code, and 1001 in a firmware-hub cycle, aborts the request.
- R8: Three consecutive 1111 SYNC nibbles abort the request, and so does a 64th consecutive wait nibble. 63 waits followed by ready complete normally. An abort holds the frame strobe low with 1111 driven for 4 clocks, then responds with rsp_abort_o=1 and rsp_rdata_o all ones.
- R9: Configuration requests, IO requests at or above 10000h and memory requests at or above 1000000h outside the TPM window still send START, type and address nibbles, but with the frame strobe high and no turnaround or SYNC. They respond with abort set and all ones.
- R10: IO writes to 80h-8Fh run as normal IO write cycles. IO reads of 80h-8Fh cause no bus activity and respond in the cycle after acceptance with all ones and no abort.
- R11: On pd_req_i the suspend status output rises one clock before the frame strobe goes low. LAD stays released until the request drops, and no request is accepted during that time. When a request and pd_req_i arrive in the same cycle, power-down wins.
- R12: req_ready_o is low from acceptance through the single-clock response and returns high in the clock after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_write_i | input | 1 | 1 = write |
| req_space_i | input | 2 | 0 memory, 1 IO, 2/3 configuration |
| req_addr_i | input | 32 | Byte address |
| req_size_i | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata_i | input | 32 | Write data, byte 0 in bits 7:0 |
| rsp_valid_o | output | 1 | Response, one clock |
| rsp_abort_o | output | 1 | Request aborted or unclaimed |
| rsp_rdata_o | output | 32 | Read data |
| pd_req_i | input | 1 | Power-down request |
| sus_stat_o | output | 1 | Suspend status, active high |
| lframe_no | output | 1 | Frame strobe, active low |
| lad_o | output | 4 | LAD value driven by host |
| lad_oe_o | output | 1 | LAD output enable |
| lad_i | input | 4 | LAD value from bus |

## Verification
The reference model in the bench builds the expected nibble, strobe and enable sequence for each request, together with the device's SYNC script. It compares the outputs on every clock. Two functions can meet in the same clock: a new request and the power-down entry. The bench raises pd_req_i at the very edge where a request first becomes valid. It then requires that the ready output stays low, that the suspend-then-park order appears with no START in between, and that the waiting request runs as a normal cycle only after pd_req_i drops.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam logic [1:0] SP_MEM = 2'd0;
  localparam logic [1:0] SP_IO  = 2'd1;

  typedef enum logic [2:0] {
    RT_MEM, RT_IO, RT_FWH, RT_TPM, RT_POST_RD, RT_NOLPC
  } route_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_TYPE, S_ADDR, S_WDATA, S_TAR_H, S_SYNC,
    S_RDATA, S_TAR_D, S_ABORT, S_DONE, S_PD_SUS, S_PD
  } state_e;

  function automatic logic [3:0] start_code(route_e r, logic wr);
    case (r)
      RT_TPM:  return 4'b0101;
      RT_FWH:  return wr ? 4'b1110 : 4'b1101;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [3:0] type_code(route_e r, logic wr);
    return {1'b0, r != RT_IO, wr, 1'b0};
  endfunction
endpackage

// File: rtl/lpc_route_dec.sv
module lpc_route_dec
  import lpc_pkg::*;
#(
  parameter logic [31:0] FW_LO   = 32'h00F0_0000,
  parameter logic [31:0] FW_HI   = 32'h00FF_FFFF,
  parameter logic [31:0] TPM_LO  = 32'hFED0_0000,
  parameter logic [31:0] TPM_HI  = 32'hFED4_0FFF,
  parameter logic [31:0] MEM_TOP = 32'h0100_0000,
  parameter logic [31:0] IO_TOP  = 32'h0001_0000,
  parameter logic [31:0] POST_LO = 32'h0000_0080,
  parameter logic [31:0] POST_HI = 32'h0000_008F
) (
  input  logic [1:0]        space_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output route_e            route_o
);
  always_comb begin
    route_o = RT_NOLPC;
    if (space_i == SP_MEM) begin
      if (addr_i >= TPM_LO && addr_i <= TPM_HI) route_o = RT_TPM;
      else if (addr_i < MEM_TOP)
        route_o = (addr_i >= FW_LO && addr_i <= FW_HI) ? RT_FWH : RT_MEM;
    end else if (space_i == SP_IO && addr_i < IO_TOP) begin
      route_o = (!write_i && addr_i >= POST_LO && addr_i <= POST_HI) ? RT_POST_RD : RT_IO;
    end
  end
endmodule

// File: rtl/lpc_rdata_pack.sv
module lpc_rdata_pack
  import lpc_pkg::*;
#(
  localparam int unsigned NIBS = DATA_W / 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [1:0]        byte_i,
  input  logic              hi_i,
  input  logic [3:0]        nib_i,
  output logic [DATA_W-1:0] word_o
);
  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_o[g*4 +: 4] <= '0;
      else if (clr_i) word_o[g*4 +: 4] <= '0;
      else if (we_i && {byte_i, hi_i} == 3'(g)) word_o[g*4 +: 4] <= nib_i;
    end
  end
endmodule

// File: rtl/lpc_cycle_seq.sv
module lpc_cycle_seq
  import lpc_pkg::*;
#(
  parameter int unsigned WAIT_LIMIT   = 64,
  parameter int unsigned NOSYNC_LIMIT = 3,
  parameter int unsigned ABORT_CLKS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  route_e            route_i,
  input  logic              pd_req_i,
  output logic              sus_stat_o,
  output logic              lframe_no,
  output logic [3:0]        lad_o,
  output logic              lad_oe_o,
  input  logic [3:0]        lad_i,
  output logic              rd_clr_o,
  output logic              rd_we_o,
  output logic [1:0]        rd_byte_o,
  output logic              rd_hi_o,
  output logic              rsp_valid_o,
  output logic              rsp_abort_o,
  output logic              rsp_ones_o
);
  localparam int unsigned WW = $clog2(WAIT_LIMIT + 1);
  localparam int unsigned FW = $clog2(NOSYNC_LIMIT + 1);

  state_e            state_q;
  route_e            route_q;
  logic              write_q, abort_q, ones_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        byte_q, last_q;
  logic [3:0]        nib_q;
  logic [WW-1:0]     wait_q;
  logic [FW-1:0]     flt_q;

  logic [ADDR_W-1:0] cur_addr;
  logic [3:0]        nib_top, nib_idx, addr_nib, data_nib;
  logic [7:0]        wbyte;
  logic              sync_rdy, sync_wait, sync_flt, accept, last_byte;

  assign cur_addr  = addr_q + ADDR_W'(byte_q);
  assign nib_top   = (route_q == RT_IO) ? 4'd3 : 4'd7;
  assign nib_idx   = nib_top - nib_q;
  assign addr_nib  = 4'(cur_addr >> {nib_idx, 2'b00});
  assign wbyte     = 8'(wdata_q >> {byte_q, 3'b000});
  assign data_nib  = nib_q[0] ? wbyte[7:4] : wbyte[3:0];
  assign sync_rdy  = (lad_i == 4'b0000) || (lad_i == 4'b1001 && route_q != RT_FWH);
  assign sync_wait = (lad_i == 4'b0101) || (lad_i == 4'b0110);
  assign sync_flt  = (lad_i == 4'b1111);
  assign last_byte = (byte_q == last_q);

  assign req_ready_o = (state_q == S_IDLE) && !pd_req_i;
  assign accept      = req_ready_o && req_valid_i;
  assign rd_clr_o    = accept;
  assign rd_we_o     = (state_q == S_RDATA);
  assign rd_byte_o   = byte_q;
  assign rd_hi_o     = nib_q[0];
  assign rsp_valid_o = (state_q == S_DONE);
  assign rsp_abort_o = rsp_valid_o && abort_q;
  assign rsp_ones_o  = ones_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;  route_q <= RT_MEM;  write_q <= 1'b0;
      abort_q <= 1'b0;    ones_q  <= 1'b0;    addr_q  <= '0;
      wdata_q <= '0;      byte_q  <= '0;      last_q  <= '0;
      nib_q   <= '0;      wait_q  <= '0;      flt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (pd_req_i) state_q <= S_PD_SUS;
          else if (req_valid_i) begin
            route_q <= route_i;
            write_q <= req_write_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            last_q  <= (req_size_i == 2'd0) ? 2'd0 : (req_size_i == 2'd1) ? 2'd1 : 2'd3;
            byte_q  <= '0;
            nib_q   <= '0;
            abort_q <= (route_i == RT_NOLPC);
            ones_q  <= (route_i == RT_NOLPC) || (route_i == RT_POST_RD);
            state_q <= (route_i == RT_POST_RD) ? S_DONE : S_START;
          end
        end
        S_START: begin
          nib_q   <= '0;
          state_q <= (route_q == RT_FWH) ? S_ADDR : S_TYPE;
        end
        S_TYPE: state_q <= S_ADDR;
        S_ADDR: begin
          if (nib_q == nib_top) begin
            nib_q <= '0;
            if (route_q == RT_NOLPC) begin
              byte_q  <= byte_q + 2'd1;
              state_q <= last_byte ? S_DONE : S_START;
            end else state_q <= write_q ? S_WDATA : S_TAR_H;
          end else nib_q <= nib_q + 4'd1;
        end
        S_WDATA: begin
          nib_q <= nib_q[0] ? 4'd0 : nib_q + 4'd1;
          if (nib_q[0]) state_q <= S_TAR_H;
        end
        S_TAR_H: begin
          nib_q <= nib_q[0] ? 4'd0 : nib_q + 4'd1;
          if (nib_q[0]) begin
            state_q <= S_SYNC;
            wait_q  <= '0;
            flt_q   <= '0;
          end
        end
        S_SYNC: begin
          if (sync_rdy) begin
            nib_q   <= '0;
            state_q <= write_q ? S_TAR_D : S_RDATA;
          end else if (sync_wait && wait_q != WW'(WAIT_LIMIT - 1)) begin
            wait_q <= wait_q + WW'(1);
            flt_q  <= '0;
          end else if (sync_flt && flt_q != FW'(NOSYNC_LIMIT - 1)) begin
            flt_q <= flt_q + FW'(1);
          end else begin
            nib_q   <= '0;
            abort_q <= 1'b1;
            ones_q  <= 1'b1;
            state_q <= S_ABORT;
          end
        end
        S_RDATA: begin
          nib_q <= nib_q[0] ? 4'd0 : nib_q + 4'd1;
          if (nib_q[0]) state_q <= S_TAR_D;
        end
        S_TAR_D: begin
          nib_q <= nib_q[0] ? 4'd0 : nib_q + 4'd1;
          if (nib_q[0]) begin
            byte_q  <= byte_q + 2'd1;
            state_q <= last_byte ? S_DONE : S_START;
          end
        end
        S_ABORT: begin
          if (nib_q == 4'(ABORT_CLKS - 1)) state_q <= S_DONE;
          else nib_q <= nib_q + 4'd1;
        end
        S_DONE:   state_q <= S_IDLE;
        S_PD_SUS: state_q <= S_PD;
        S_PD:     if (!pd_req_i) state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    lframe_no  = 1'b1;
    lad_oe_o   = 1'b0;
    lad_o      = 4'hF;
    sus_stat_o = 1'b0;
    unique case (state_q)
      S_START: begin
        lframe_no = (route_q == RT_NOLPC);
        lad_oe_o  = 1'b1;
        lad_o     = start_code(route_q, write_q);
      end
      S_TYPE:  begin lad_oe_o = 1'b1; lad_o = type_code(route_q, write_q); end
      S_ADDR:  begin lad_oe_o = 1'b1; lad_o = addr_nib; end
      S_WDATA: begin lad_oe_o = 1'b1; lad_o = data_nib; end
      S_TAR_H: lad_oe_o = !nib_q[0];
      S_ABORT: begin lframe_no = 1'b0; lad_oe_o = 1'b1; end
      S_PD_SUS: sus_stat_o = 1'b1;
      S_PD:    begin sus_stat_o = 1'b1; lframe_no = 1'b0; lad_o = 4'h0; end
      default: ;
    endcase
  end

  AST_RSP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o); // R12
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R12
  AST_PD_SUS_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(lframe_no) && sus_stat_o) |-> $past(sus_stat_o)); // R11
  AST_PD_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sus_stat_o && !lframe_no) |-> !lad_oe_o); // R11
  AST_PD_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sus_stat_o |-> !req_ready_o); // R11
endmodule

// File: rtl/lpc_host_engine.sv
module lpc_host_engine
  import lpc_pkg::*;
#(
  parameter logic [31:0] FW_LO        = 32'h00F0_0000,
  parameter logic [31:0] FW_HI        = 32'h00FF_FFFF,
  parameter logic [31:0] TPM_LO       = 32'hFED0_0000,
  parameter logic [31:0] TPM_HI       = 32'hFED4_0FFF,
  parameter int unsigned WAIT_LIMIT   = 64,
  parameter int unsigned NOSYNC_LIMIT = 3,
  parameter int unsigned ABORT_CLKS   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [1:0]  req_space_i,
  input  logic [31:0] req_addr_i,
  input  logic [1:0]  req_size_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic        rsp_abort_o,
  output logic [31:0] rsp_rdata_o,
  input  logic        pd_req_i,
  output logic        sus_stat_o,
  output logic        lframe_no,
  output logic [3:0]  lad_o,
  output logic        lad_oe_o,
  input  logic [3:0]  lad_i
);
  route_e            route;
  logic              rd_clr, rd_we, rd_hi, ones;
  logic [1:0]        rd_byte;
  logic [DATA_W-1:0] packed_rd;

  lpc_route_dec #(
    .FW_LO(FW_LO), .FW_HI(FW_HI), .TPM_LO(TPM_LO), .TPM_HI(TPM_HI)
  ) u_dec (
    .space_i(req_space_i), .write_i(req_write_i), .addr_i(req_addr_i), .route_o(route)
  );

  lpc_cycle_seq #(
    .WAIT_LIMIT(WAIT_LIMIT), .NOSYNC_LIMIT(NOSYNC_LIMIT), .ABORT_CLKS(ABORT_CLKS)
  ) u_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_write_i, .req_size_i,
    .req_addr_i, .req_wdata_i, .route_i(route), .pd_req_i, .sus_stat_o,
    .lframe_no, .lad_o, .lad_oe_o, .lad_i,
    .rd_clr_o(rd_clr), .rd_we_o(rd_we), .rd_byte_o(rd_byte), .rd_hi_o(rd_hi),
    .rsp_valid_o, .rsp_abort_o, .rsp_ones_o(ones)
  );

  lpc_rdata_pack u_pack (
    .clk_i, .rst_ni, .clr_i(rd_clr), .we_i(rd_we), .byte_i(rd_byte),
    .hi_i(rd_hi), .nib_i(lad_i), .word_o(packed_rd)
  );

  assign rsp_rdata_o = ones ? '1 : packed_rd;

  AST_ABORT_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_abort_o) |-> (rsp_rdata_o == '1)); // R8
endmodule

// File: tb/tb_lpc_host_engine.sv
`timescale 1ns/1ps
module tb_lpc_host_engine;
  localparam int K_MEM = 0, K_IO = 1, K_FWH = 2, K_TPM = 3, K_POST = 4, K_NOLPC = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, pd_req = 1'b0;
  logic [1:0]  req_space = '0, req_size = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  lad_in = 4'hF;
  logic        req_ready, rsp_valid, rsp_abort, sus_stat, lframe_n, lad_oe;
  logic [31:0] rsp_rdata;
  logic [3:0]  lad_out;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  lpc_host_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_space_i(req_space), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid),
    .rsp_abort_o(rsp_abort), .rsp_rdata_o(rsp_rdata), .pd_req_i(pd_req),
    .sus_stat_o(sus_stat), .lframe_no(lframe_n), .lad_o(lad_out),
    .lad_oe_o(lad_oe), .lad_i(lad_in)
  );

  typedef struct packed {
    logic       fr_n;
    logic       oe;
    logic [3:0] lad;
    logic [3:0] drv;
    logic       rsp;
  } step_t;

  step_t q[$];

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void push(logic fr_n, logic oe, logic [3:0] lad, logic [3:0] drv, logic rsp);
    step_t s;
    s.fr_n = fr_n; s.oe = oe; s.lad = lad; s.drv = drv; s.rsp = rsp;
    q.push_back(s);
  endfunction

  function automatic int kind_of(logic [1:0] sp, logic wr, logic [31:0] a);
    if (sp == 2'd0) begin
      if (a >= 32'hFED0_0000 && a <= 32'hFED4_0FFF) return K_TPM;
      if (a < 32'h0100_0000) return (a >= 32'h00F0_0000) ? K_FWH : K_MEM;
      return K_NOLPC;
    end
    if (sp == 2'd1 && a < 32'h0001_0000)
      return (!wr && a >= 32'h80 && a <= 32'h8F) ? K_POST : K_IO;
    return K_NOLPC;
  endfunction

  task automatic run(string tag, logic [1:0] sp, logic wr, logic [31:0] a, logic [1:0] sz,
                     logic [31:0] wd, int n_pre, logic [3:0] pre, logic [3:0] fin, logic [7:0] rb);
    int kind, nb, na;
    bit ab;
    logic [31:0] rd, exp_rd;
    kind = kind_of(sp, wr, a);
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    q.delete();
    ab = 0;
    rd = '0;
    if (kind != K_POST) begin
      for (int b = 0; b < nb; b++) begin
        logic [31:0] ca;
        logic [7:0]  wb;
        logic [3:0]  st;
        int waits, flts, idx;
        bit done;
        ca = a + 32'(b);
        wb = 8'(wd >> (8 * b));
        st = (kind == K_TPM) ? 4'b0101 : (kind == K_FWH) ? (wr ? 4'b1110 : 4'b1101) : 4'b0000;
        push(kind == K_NOLPC, 1, st, 4'hF, 0);
        if (kind != K_FWH) push(1, 1, {1'b0, kind != K_IO, wr, 1'b0}, 4'hF, 0);
        na = (kind == K_IO) ? 4 : 8;
        for (int n = na - 1; n >= 0; n--) push(1, 1, 4'(ca >> (4 * n)), 4'hF, 0);
        if (kind == K_NOLPC) continue;
        if (wr) begin push(1, 1, wb[3:0], 4'hF, 0); push(1, 1, wb[7:4], 4'hF, 0); end
        push(1, 1, 4'hF, 4'hF, 0);
        push(1, 0, 4'hF, 4'hF, 0);
        waits = 0; flts = 0; idx = 0; done = 0;
        while (!done && !ab) begin
          logic [3:0] code;
          code = (idx < n_pre) ? pre : fin;
          idx++;
          push(1, 0, 4'hF, code, 0);
          if (code == 4'h0 || (code == 4'h9 && kind != K_FWH)) done = 1;
          else if (code == 4'h5 || code == 4'h6) begin
            flts = 0; waits++;
            if (waits == 64) ab = 1;
          end else if (code == 4'hF) begin
            flts++;
            if (flts == 3) ab = 1;
          end else ab = 1;
        end
        if (ab) begin
          for (int k = 0; k < 4; k++) push(0, 1, 4'hF, 4'hF, 0);
          break;
        end
        if (!wr) begin
          logic [7:0] v;
          v = rb + 8'(b);
          push(1, 0, 4'hF, v[3:0], 0);
          push(1, 0, 4'hF, v[7:4], 0);
          rd[8*b +: 8] = v;
        end
        push(1, 0, 4'hF, 4'hF, 0);
        push(1, 0, 4'hF, 4'hF, 0);
      end
      if (kind == K_NOLPC) ab = 1;
    end
    push(1, 0, 4'hF, 4'hF, 1);
    exp_rd = (ab || kind == K_POST) ? 32'hFFFF_FFFF : rd;

    @(negedge clk);
    req_valid = 1; req_write = wr; req_space = sp; req_addr = a;
    req_size = sz; req_wdata = wd;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    foreach (q[i]) begin
      lad_in = q[i].drv;
      #1;
      chk(lframe_n == q[i].fr_n, tag, $sformatf("frame step %0d", i), 32'(lframe_n), 32'(q[i].fr_n));
      chk(lad_oe == q[i].oe, tag, $sformatf("lad_oe step %0d", i), 32'(lad_oe), 32'(q[i].oe));
      if (q[i].oe)
        chk(lad_out == q[i].lad, tag, $sformatf("lad step %0d", i), 32'(lad_out), 32'(q[i].lad));
      chk(rsp_valid == q[i].rsp, tag, $sformatf("rsp_valid step %0d", i), 32'(rsp_valid), 32'(q[i].rsp));
      chk(!req_ready, "R12", $sformatf("ready low busy step %0d (%s)", i, tag), 32'(req_ready), 0);
      if (q[i].rsp) begin
        chk(rsp_rdata == exp_rd, tag, "rdata", rsp_rdata, exp_rd);
        chk(rsp_abort == ab, tag, "abort", 32'(rsp_abort), 32'(ab));
      end
      @(negedge clk);
    end
    lad_in = 4'hF;
    #1;
    chk(req_ready, "R12", "ready back after response", 32'(req_ready), 1);
    chk(!rsp_valid, "R12", "response single clock", 32'(rsp_valid), 0);
  endtask

  // caller has set pd_req at a negedge
  task automatic pd_seq(int hold);
    #1;
    chk(!req_ready, "R11", "ready low on pd", 32'(req_ready), 0);
    @(negedge clk); #1;
    chk(sus_stat && lframe_n, "R11", "sus before frame", {30'b0, sus_stat, lframe_n}, 32'h3);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk); #1;
      chk(sus_stat && !lframe_n && !lad_oe, "R11", "parked",
          {29'b0, sus_stat, lframe_n, lad_oe}, 32'h4);
      chk(!req_ready, "R11", "no accept while parked", 32'(req_ready), 0);
    end
    pd_req = 0;
    @(negedge clk); #1;
    chk(!sus_stat && lframe_n, "R11", "released", {30'b0, sus_stat, lframe_n}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(lframe_n && !lad_oe && !sus_stat && !rsp_valid, "R12", "reset outputs",
        {28'b0, lframe_n, lad_oe, sus_stat, rsp_valid}, 32'h8);
    rst_n = 1;
    @(negedge clk); #1;
    chk(req_ready, "R12", "ready after reset", 32'(req_ready), 1);

    run("R2", 2'd0, 0, 32'h0001_2345, 2'd0, 0, 0, 4'h0, 4'h0, 8'hA0);
    run("R1", 2'd0, 1, 32'h0000_FFFE, 2'd2, 32'hDEAD_BEEF, 0, 4'h0, 4'h0, 8'h00);
    run("R1", 2'd0, 0, 32'h0080_0000, 2'd1, 0, 0, 4'h0, 4'h0, 8'h5C);
    run("R3", 2'd0, 0, 32'h00F8_0010, 2'd1, 0, 3, 4'h6, 4'h0, 8'h31);
    run("R3", 2'd0, 1, 32'h00F0_0000, 2'd0, 32'h0000_0077, 2, 4'h5, 4'h0, 8'h00);
    run("R7", 2'd0, 0, 32'h00FF_0000, 2'd0, 0, 0, 4'h0, 4'h9, 8'h11);
    run("R4", 2'd0, 0, 32'hFED4_0FFF, 2'd0, 0, 2, 4'hF, 4'h0, 8'hE7);
    run("R4", 2'd0, 1, 32'hFED0_0000, 2'd1, 32'h0000_1234, 0, 4'h0, 4'h0, 8'h00);
    run("R9", 2'd0, 0, 32'hFED4_1000, 2'd0, 0, 0, 4'h0, 4'h0, 8'h00);
    run("R5", 2'd1, 0, 32'h0000_0060, 2'd1, 0, 0, 4'h0, 4'h9, 8'h42);
    run("R5", 2'd1, 1, 32'h0000_03F8, 2'd0, 32'h0000_00A5, 1, 4'h5, 4'h0, 8'h00);
    run("R6", 2'd1, 0, 32'h0000_0070, 2'd0, 0, 0, 4'h0, 4'h0, 8'h96);
    run("R10", 2'd1, 1, 32'h0000_0080, 2'd0, 32'h0000_0012, 0, 4'h0, 4'h0, 8'h00);
    run("R10", 2'd1, 0, 32'h0000_008F, 2'd0, 0, 0, 4'h0, 4'h0, 8'h00);
    run("R10", 2'd1, 0, 32'h0000_0090, 2'd0, 0, 0, 4'h0, 4'h0, 8'h3B);
    run("R8", 2'd0, 0, 32'h0000_1000, 2'd2, 0, 0, 4'h0, 4'hF, 8'h00);
    run("R8", 2'd0, 0, 32'h0000_2000, 2'd0, 0, 70, 4'h6, 4'h0, 8'h00);
    run("R8", 2'd0, 0, 32'h0000_3000, 2'd0, 0, 63, 4'h6, 4'h0, 8'hC4);
    run("R7", 2'd0, 1, 32'h0000_4000, 2'd1, 32'h0000_5566, 0, 4'h0, 4'hA, 8'h00);
    run("R9", 2'd2, 0, 32'h0000_0010, 2'd0, 0, 0, 4'h0, 4'h0, 8'h00);
    run("R9", 2'd1, 1, 32'h0001_0000, 2'd0, 32'h0000_0001, 0, 4'h0, 4'h0, 8'h00);
    run("R9", 2'd0, 0, 32'h0100_0000, 2'd1, 0, 0, 4'h0, 4'h0, 8'h00);

    @(negedge clk);
    pd_req = 1;
    pd_seq(5);

    // request and power-down raised at the same edge
    fork
      run("R11", 2'd0, 0, 32'h0000_0ABC, 2'd0, 0, 0, 4'h0, 4'h0, 8'h6D);
      begin
        @(negedge clk);
        pd_req = 1;
        pd_seq(4);
      end
    join

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule